// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block receives 8-bit frames on a serial data line that is clocked by an external serial clock. It brings both lines into the system clock domain through a two-flop synchronizer and samples the data line on each rising serial-clock edge. The least significant bit arrives first. When the eighth bit has been taken, the frame moves into a receive data register and a data-ready flag is set. The flag stays set until the host reads that register.

If a further frame completes before the host has read the register, an overrun flag is raised. The unread frame stays in the register and the new frame is discarded. While the overrun flag is set, reception is frozen and serial-clock edges have no effect. The host clears the overrun flag by writing 0 to its bit. The host reaches the block through a small register bus with a data register, a status register and a control register that holds the receive-enable bit.

Top module: `sync_rx_unit`

## Requirements
- R1: A frame is 8 bits, sampled on rising serial-clock edges, with the first bit sampled becoming bit 0 and the eighth becoming bit 7 of the received byte.
- R2: When a frame completes while the data-ready flag is 0, the byte is placed in the data register (address 0) and the data-ready flag (status address 1, bit 6, also on output `rx_ready`) becomes 1.
- R3: A host read of address 0 clears the data-ready flag to 0.
- R4: When a frame completes while the data-ready flag is 1, the overrun flag (status bit 5, also on output `rx_overrun`) becomes 1. The data register keeps the earlier byte and the new byte is discarded.
- R5: While the overrun flag is 1, serial-clock edges change nothing: no frame is assembled or delivered. After the flag is cleared, the next frame is assembled from its first bit.
- R6: Writing status with bit 5 equal to 0 clears the overrun flag. Writing bit 5 as 1 leaves it unchanged. A status write never changes the data-ready flag.
- R7: When receive-enable (control address 2, bit 4) is 0, no frame is received and the bit counter returns to zero, so a partial frame is dropped.
- R8: After reset, the data register, both flags and the control register read 0. Control reads back the value of its enable bit, and unused register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | External serial clock, asynchronous |
| ser_data | input | 1 | Serial data line, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_ready | output | 1 | Data-ready flag |
| rx_overrun | output | 1 | Overrun flag |

## Verification
Every one of the 256 byte values is sent as a frame and read back. A swapped bit order, a missing bit or a stuck bit therefore shows up as a value mismatch. Two frames sent back to back without a read separate keeping the old byte from overwriting it. A third frame sent during overrun shows whether reception really stalls. A frame sent after the clear shows whether the bit counter restarted. Status writes with each flag bit at 1 and at 0 show that the flags respond only to the permitted writes. Frames sent with receive-enable off, and a partial frame cut short by turning enable off, show the enable gating and the counter reset.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DATA   = 2'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  localparam int READY_BIT  = 6;
  localparam int OVR_BIT    = 5;
  localparam int ENABLE_BIT = 4;

  // Shift a new serial bit in at the top; earlier bits move toward bit 0.
  function automatic logic [BYTE_W-1:0] shift_lsb_first(
      input logic [BYTE_W-1:0] cur, input logic din);
    return {din, cur[BYTE_W-1:1]};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic ready,
                                                    input logic ovr);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[READY_BIT] = ready;
    s[OVR_BIT]   = ovr;
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ctrl(input logic en);
    logic [BYTE_W-1:0] c;
    c = '0;
    c[ENABLE_BIT] = en;
    return c;
  endfunction
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_async,
  input  logic sd_async,
  output logic sck_rise,
  output logic sd_sync
);
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] sd_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      sd_pipe  <= '0;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-1:0], sck_async};
      sd_pipe  <= {sd_pipe[STAGES-2:0], sd_async};
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sd_sync  = sd_pipe[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import sync_rx_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         stall,
  input  logic         bit_strobe,
  input  logic         bit_in,
  output logic         frame_done,
  output logic [W-1:0] frame_byte
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [W-1:0]     shreg;
  logic             active;

  assign active = enable && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
      frame_byte <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (bit_strobe) begin
        shreg <= shift_lsb_first(shreg, bit_in);
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
          frame_byte <= shift_lsb_first(shreg, bit_in);
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R5
  no_frame_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall) |-> !frame_done);
  // R7
  cnt_idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> bit_cnt == '0);
  // R1
  frame_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bit_strobe));
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import sync_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [BYTE_W-1:0] frame_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              ready,
  output logic              ovr,
  output logic              enable
);
  logic [BYTE_W-1:0] data_q;
  logic              data_read_evt;
  logic              ovr_clear_evt;
  logic              ctrl_write_evt;
  logic              accept_evt;
  logic              overrun_evt;
  logic              unused_wdata;

  assign data_read_evt  = rd && (addr == A_DATA);
  assign ovr_clear_evt  = wr && (addr == A_STATUS) && !wdata[OVR_BIT];
  assign ctrl_write_evt = wr && (addr == A_CTRL);
  assign accept_evt     = frame_done && !ready;
  assign overrun_evt    = frame_done && ready;
  assign unused_wdata   = ^{wdata[BYTE_W-1:OVR_BIT+1], wdata[OVR_BIT-1:ENABLE_BIT+1],
                            wdata[ENABLE_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ready  <= 1'b0;
      ovr    <= 1'b0;
      enable <= 1'b0;
    end else begin
      if (accept_evt) begin
        data_q <= frame_byte;
        ready  <= 1'b1;
      end else if (data_read_evt) begin
        ready <= 1'b0;
      end
      if (overrun_evt)        ovr <= 1'b1;
      else if (ovr_clear_evt) ovr <= 1'b0;
      if (ctrl_write_evt) enable <= wdata[ENABLE_BIT];
    end
  end

  always_comb begin
    case (addr)
      A_DATA:   rdata = data_q;
      A_STATUS: rdata = pack_status(ready, ovr);
      A_CTRL:   rdata = pack_ctrl(enable);
      default:  rdata = '0;
    endcase
  end

  // R2
  ready_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(frame_done));
  // R3
  ready_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(data_read_evt));
  // R4
  ovr_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(frame_done && ready));
  // R4
  keep_old_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> $stable(data_q));
  // R6
  ovr_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(ovr_clear_evt));
endmodule

// File: rtl/sync_rx_unit.sv
module sync_rx_unit
  import sync_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              rx_ready,
  output logic              rx_overrun
);
  logic              sck_rise;
  logic              sd_sync;
  logic              frame_done;
  logic [BYTE_W-1:0] frame_byte;
  logic              rx_enable;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_async(ser_clk), .sd_async(ser_data),
    .sck_rise(sck_rise), .sd_sync(sd_sync));

  rx_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable), .stall(rx_overrun),
    .bit_strobe(sck_rise), .bit_in(sd_sync),
    .frame_done(frame_done), .frame_byte(frame_byte));

  rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_byte(frame_byte),
    .addr(reg_addr), .rd(reg_rd), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ready(rx_ready), .ovr(rx_overrun), .enable(rx_enable));

  // R5
  overrun_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && $past(rx_overrun) |-> $stable(rx_ready) || !rx_ready);
endmodule

// File: tb/sync_rx_unit_tb.sv
module sync_rx_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_ready;
  logic       rx_overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_rx_unit u_dut (.*);

  function automatic logic [7:0] st(input bit rdy, input bit ov);
    return (rdy ? 8'd64 : 8'd0) + (ov ? 8'd32 : 8'd0);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset values
    reg_read(2'd1, v); check("R8 status", v, 8'h00);
    reg_read(2'd2, v); check("R8 ctrl", v, 8'h00);
    reg_read(2'd0, v); check("R8 data", v, 8'h00);
    check("R8 pins", {6'd0, rx_ready, rx_overrun}, 8'h00);
    // R7 disabled: no reception
    send_byte(8'h5A);
    reg_read(2'd1, v); check("R7 off status", v, 8'h00);
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, v); check("R8 ctrl readback", v, 8'h10);

    // R1 R2 R3 every byte value
    for (int b = 0; b < 256; b++) begin
      send_byte(b[7:0]);
      reg_read(2'd1, v); check("R2 ready set", v, st(1, 0));
      check("R2 ready pin", {7'd0, rx_ready}, 8'h01);
      reg_read(2'd0, v); check("R1 byte value", v, b[7:0]);
      reg_read(2'd1, v); check("R3 ready cleared", v, st(0, 0));
    end

    // R4 overrun
    send_byte(8'hA1);
    send_byte(8'hB2);
    reg_read(2'd1, v); check("R4 overrun set", v, st(1, 1));
    check("R4 overrun pin", {7'd0, rx_overrun}, 8'h01);
    // R6 writing 1s has no effect
    reg_write(2'd1, 8'hFF);
    reg_read(2'd1, v); check("R6 write ones", v, st(1, 1));
    // R6 clearing overrun does not clear ready
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v); check("R6 clear ovr keeps ready", v, st(1, 0));
    reg_read(2'd0, v); check("R4 old byte kept", v, 8'hA1);
    // overrun again, then stall
    send_byte(8'hC3);
    send_byte(8'hD4);
    reg_read(2'd1, v); check("R4 second overrun", v, st(1, 1));
    reg_read(2'd0, v); check("R4 kept C3", v, 8'hC3);
    send_byte(8'hE5);
    reg_read(2'd1, v); check("R5 stalled", v, st(0, 1));
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    reg_write(2'd1, 8'h40);
    reg_read(2'd1, v); check("R6 cleared, ready not set", v, st(0, 0));
    send_byte(8'h96);
    reg_read(2'd1, v); check("R5 resumed", v, st(1, 0));
    reg_read(2'd0, v); check("R5 fresh frame", v, 8'h96);

    // R7 partial frame dropped by disable
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    reg_write(2'd2, 8'h00);
    reg_write(2'd2, 8'h10);
    send_byte(8'h3C);
    reg_read(2'd1, v); check("R7 after reenable", v, st(1, 0));
    reg_read(2'd0, v); check("R7 counter reset", v, 8'h3C);
    reg_write(2'd2, 8'h00);
    send_byte(8'h77);
    reg_read(2'd1, v); check("R7 disabled again", v, st(0, 0));
    reg_read(2'd0, v); check("R7 data unchanged", v, 8'h3C);
    reg_read(2'd3, v); check("R8 unused addr", v, 8'h00);
    finish_run();
  end
endmodule